// File: doc/BRIEF.md
# Two-Motor Interleaved Step Sequencer

This block plays back step schedules for two stepper motors from a small command queue. A command enters as a burst of 32-bit entries over a valid/ready input. Each entry names one motor and gives the wait, in clock cycles, before that motor takes its next step. The beat that closes the burst also carries one direction bit per motor. Commands are stored in a four-slot ring buffer, and the engine always works on the oldest one.

For every entry, the engine counts down the wait. It then drives the chosen motor's direction line, holds that line for a setup interval, and raises that motor's step line for a fixed width. After the last entry of a command the engine releases the slot and moves on to the next command.

Each motor has a signed step position that follows every pulse. A busy flag reports that work is still queued. The clock is 100 MHz, so one delay unit is 10 ns.

Top module: `step_sequencer`

## Requirements
- R1: After reset, `busy` is 0, `in_ready` is 1, both `step_out` bits and both `dir_out` bits are 0, and `pos_m0` and `pos_m1` are 0.
- R2: Bit 31 of an entry selects the motor, with 0 selecting `step_out[0]` and 1 selecting `step_out[1]`. Bits 30:0 give the wait in cycles, and a wait of 0 is played as a wait of 1.
- R3: For each entry, `dir_out[m]` of the selected motor m takes the command's direction bit m (bit 0 belongs to motor 0). This happens exactly 16 cycles before the step rises. The other motor's direction line keeps its value, and no direction line changes while a step is high.
- R4: Every step pulse is high for exactly 200 cycles, and at most one step output is high at any time.
- R5: Assume a command's last beat is accepted while the engine is idle, and its first entry has wait D. The first step then rises D+17 cycles after the accepting clock edge. Within one command, consecutive rising edges are 216+D apart, where D is the later entry's effective wait.
- R6: Commands play in the order they were accepted. A command is released when its last step falls. The next command's first rise follows that fall by 17+D cycles. `busy` is high while any command is queued and falls on the same edge as the last step of the last command.
- R7: A command is a burst of beats ended by `in_last`, and the direction bits are taken from the last beat. The queue holds 4 commands. `in_ready` is low while 4 commands are held and rises on the edge that releases one.
- R8: A command keeps at most its first 64 entries. Further beats of the same burst are accepted but produce no steps.
- R9: Each rising step changes that motor's signed 32-bit position by +1 when its direction is 1 and by -1 when it is 0, on the same edge. Positions do not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | an entry beat is presented |
| in_ready | output | 1 | the queue can take a beat |
| in_dir | input | 2 | direction per motor, used from the last beat |
| in_entry | input | 32 | motor select in bit 31, wait in bits 30:0 |
| in_last | input | 1 | this beat ends the command |
| step_out | output | 2 | step pulse per motor |
| dir_out | output | 2 | direction line per motor |
| pos_m0 | output | 32 | signed step position of motor 0 |
| pos_m1 | output | 32 | signed step position of motor 1 |
| busy | output | 1 | at least one command is queued |

## Verification
The timing of each result, counted from the edge that causes it, is:

| Result | When it is due |
|---|---|
| First rising step from an idle engine | D+17 edges after the edge that accepts the last beat |
| Next rising step within one command | 216+D edges after the previous rise |
| First rising step of a following command | 217+D edges after the previous rise |
| Falling step | exactly 200 edges after its rise |
| Position update | on the same edge as the rising step |
| `busy` falling | on the same edge as the final falling step |
| `in_ready` rising after a full queue | on the edge where a step falls and releases its slot |

The bench logs the edge count of every step transition on the falling clock edge, away from the active edge. It compares each logged count with these figures, computed from the requirements.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    localparam int N_MOTORS = 2;
    localparam int ENTRY_W  = 32;
    localparam int DELAY_W  = ENTRY_W - 1;

    typedef logic [DELAY_W-1:0] delay_t;

    typedef struct packed {
        logic   motor;
        delay_t delay;
    } entry_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WAIT,
        PS_SETUP,
        PS_PULSE
    } play_state_e;

    // Countdown start for a wait phase: a zero wait still lasts one cycle.
    function automatic delay_t wait_load(delay_t d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

endpackage

// File: rtl/step_cmd_queue.sv
module step_cmd_queue
    import step_seq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ENTRIES = 64,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [N_MOTORS-1:0] wr_dir,
    input  entry_t              wr_entry,
    input  logic                wr_last,
    input  logic [IDX_W-1:0]    rd_idx,
    output entry_t              rd_entry,
    output logic [N_MOTORS-1:0] rd_dir,
    output logic [CNT_W-1:0]    rd_count,
    input  logic                pop,
    output logic                empty
);

    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(ENTRIES);
    localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP  = PTR_W'(DEPTH - 1);

    entry_t              slot_mem [DEPTH][ENTRIES];
    logic [CNT_W-1:0]    slot_cnt [DEPTH];
    logic [N_MOTORS-1:0] slot_dir [DEPTH];

    logic [PTR_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q;
    logic [CNT_W-1:0] fill_q, fill_next;
    logic             accept, commit, room;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_TOP) ? '0 : p + 1'b1;
    endfunction

    assign wr_ready  = (occ_q != OCC_MAX);
    assign empty     = (occ_q == '0);
    assign accept    = wr_valid && wr_ready;
    assign commit    = accept && wr_last;
    assign room      = (fill_q < FILL_MAX);
    assign fill_next = room ? fill_q + 1'b1 : fill_q;

    // Storage: beats past the slot capacity are dropped.
    always_ff @(posedge clk) begin
        if (accept && room) begin
            slot_mem[tail_q][fill_q[IDX_W-1:0]] <= wr_entry;
        end
        if (commit) begin
            slot_cnt[tail_q] <= fill_next;
            slot_dir[tail_q] <= wr_dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
            fill_q <= '0;
        end else begin
            if (accept) begin
                fill_q <= commit ? '0 : fill_next;
            end
            if (commit) begin
                tail_q <= ptr_inc(tail_q);
            end
            if (pop) begin
                head_q <= ptr_inc(head_q);
            end
            case ({commit, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign rd_entry = slot_mem[head_q][rd_idx];
    assign rd_dir   = slot_dir[head_q];
    assign rd_count = slot_cnt[head_q];

endmodule

// File: rtl/step_play_fsm.sv
module step_play_fsm
    import step_seq_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int SETUP_CYC = 16,
    parameter int PULSE_CYC = 200,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                q_empty,
    input  entry_t              q_entry,
    input  logic [N_MOTORS-1:0] q_dir,
    input  logic [CNT_W-1:0]    q_count,
    output logic [IDX_W-1:0]    rd_idx,
    output logic                q_pop,
    output logic [N_MOTORS-1:0] step_o,
    output logic [N_MOTORS-1:0] dir_o,
    output logic                evt_o,
    output logic                evt_motor_o,
    output logic                evt_up_o
);

    localparam delay_t SETUP_LD = DELAY_W'(SETUP_CYC - 1);
    localparam delay_t PULSE_LD = DELAY_W'(PULSE_CYC - 1);

    play_state_e         state_q;
    delay_t              timer_q;
    logic [IDX_W-1:0]    idx_q;
    logic                motor_q;
    logic [N_MOTORS-1:0] step_q, dir_q;
    logic [CNT_W-1:0]    idx_after;
    logic                last_entry, advance, timer_zero;

    assign timer_zero = (timer_q == '0);
    assign idx_after  = {1'b0, idx_q} + 1'b1;
    assign last_entry = (idx_after == q_count);
    assign advance    = (state_q == PS_PULSE) && timer_zero;

    // Read the following entry one cycle early so its wait loads at pulse end.
    assign rd_idx = (advance && !last_entry) ? idx_q + 1'b1 : idx_q;
    assign q_pop  = advance && last_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            timer_q <= '0;
            idx_q   <= '0;
            motor_q <= 1'b0;
            step_q  <= '0;
            dir_q   <= '0;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    if (!q_empty) begin
                        timer_q <= wait_load(q_entry.delay);
                        state_q <= PS_WAIT;
                    end
                end
                PS_WAIT: begin
                    if (timer_zero) begin
                        dir_q[q_entry.motor] <= q_dir[q_entry.motor];
                        motor_q <= q_entry.motor;
                        timer_q <= SETUP_LD;
                        state_q <= PS_SETUP;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                PS_SETUP: begin
                    if (timer_zero) begin
                        step_q[motor_q] <= 1'b1;
                        timer_q <= PULSE_LD;
                        state_q <= PS_PULSE;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                PS_PULSE: begin
                    if (timer_zero) begin
                        step_q <= '0;
                        if (last_entry) begin
                            idx_q   <= '0;
                            state_q <= PS_IDLE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            timer_q <= wait_load(q_entry.delay);
                            state_q <= PS_WAIT;
                        end
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    assign step_o      = step_q;
    assign dir_o       = dir_q;
    assign evt_o       = (state_q == PS_SETUP) && timer_zero;
    assign evt_motor_o = motor_q;
    assign evt_up_o    = dir_q[motor_q];

endmodule

// File: rtl/step_pos_track.sv
module step_pos_track #(
    parameter int POS_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hit,
    input  logic                    up,
    output logic signed [POS_W-1:0] pos
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (hit) begin
            pos <= up ? pos + POS_W'(1) : pos - POS_W'(1);
        end
    end

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import step_seq_pkg::*;
#(
    parameter int Q_DEPTH     = 4,
    parameter int MAX_ENTRIES = 64,
    parameter int SETUP_CYC   = 16,
    parameter int PULSE_CYC   = 200,
    parameter int POS_W       = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [N_MOTORS-1:0]     in_dir,
    input  logic [ENTRY_W-1:0]      in_entry,
    input  logic                    in_last,
    output logic [N_MOTORS-1:0]     step_out,
    output logic [N_MOTORS-1:0]     dir_out,
    output logic signed [POS_W-1:0] pos_m0,
    output logic signed [POS_W-1:0] pos_m1,
    output logic                    busy
);

    localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
    localparam int CNT_W = IDX_W + 1;

    entry_t              head_entry;
    logic [N_MOTORS-1:0] head_dir;
    logic [CNT_W-1:0]    head_count;
    logic [IDX_W-1:0]    rd_idx;
    logic                q_empty, q_pop;
    logic                evt, evt_motor, evt_up;
    logic signed [POS_W-1:0] pos_arr [N_MOTORS];

    step_cmd_queue #(
        .DEPTH   (Q_DEPTH),
        .ENTRIES (MAX_ENTRIES)
    ) u_queue (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (in_valid),
        .wr_ready (in_ready),
        .wr_dir   (in_dir),
        .wr_entry (entry_t'(in_entry)),
        .wr_last  (in_last),
        .rd_idx   (rd_idx),
        .rd_entry (head_entry),
        .rd_dir   (head_dir),
        .rd_count (head_count),
        .pop      (q_pop),
        .empty    (q_empty)
    );

    step_play_fsm #(
        .ENTRIES   (MAX_ENTRIES),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_play (
        .clk         (clk),
        .rst         (rst),
        .q_empty     (q_empty),
        .q_entry     (head_entry),
        .q_dir       (head_dir),
        .q_count     (head_count),
        .rd_idx      (rd_idx),
        .q_pop       (q_pop),
        .step_o      (step_out),
        .dir_o       (dir_out),
        .evt_o       (evt),
        .evt_motor_o (evt_motor),
        .evt_up_o    (evt_up)
    );

    for (genvar m = 0; m < N_MOTORS; m++) begin : g_pos
        step_pos_track #(
            .POS_W (POS_W)
        ) u_pos (
            .clk (clk),
            .rst (rst),
            .hit (evt && (evt_motor == 1'(m))),
            .up  (evt_up),
            .pos (pos_arr[m])
        );
    end

    assign pos_m0 = pos_arr[0];
    assign pos_m1 = pos_arr[1];
    assign busy   = !q_empty;

endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk #(
    parameter int SETUP_CYC = 16,
    parameter int PULSE_CYC = 200,
    parameter int POS_W     = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_ready,
    input logic [1:0]              step_out,
    input logic [1:0]              dir_out,
    input logic signed [POS_W-1:0] pos_m0,
    input logic signed [POS_W-1:0] pos_m1,
    input logic                    busy
);

    logic [31:0] hi_cnt, since_dir;
    logic [1:0]  dir_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            since_dir <= '0;
            dir_seen  <= '0;
        end else begin
            hi_cnt    <= (|step_out) ? hi_cnt + 1'b1 : '0;
            dir_seen  <= dir_out;
            if (dir_out != dir_seen) begin
                since_dir <= 32'd1;
            end else if (since_dir != 32'hFFFF_FFFF) begin
                since_dir <= since_dir + 1'b1;
            end
        end
    end

    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_out)); // R4
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(|step_out) |-> (hi_cnt == 32'(PULSE_CYC))); // R4
    AST_DIR_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(|step_out) |-> (since_dir >= 32'(SETUP_CYC))); // R3
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|step_out) |-> $stable(dir_out)); // R3
    AST_BUSY_WHILE_STEP: assert property (@(posedge clk) disable iff (rst)
        (|step_out) |-> busy); // R6
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> in_ready); // R7
    AST_POS0_UP: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_out[0]) && dir_out[0]) |-> (pos_m0 == $past(pos_m0) + POS_W'(1))); // R9
    AST_POS0_DOWN: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_out[0]) && !dir_out[0]) |-> (pos_m0 == $past(pos_m0) - POS_W'(1))); // R9
    AST_POS1_UP: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_out[1]) && dir_out[1]) |-> (pos_m1 == $past(pos_m1) + POS_W'(1))); // R9
    AST_POS1_DOWN: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_out[1]) && !dir_out[1]) |-> (pos_m1 == $past(pos_m1) - POS_W'(1))); // R9
    AST_POS0_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(step_out[0]) |-> $stable(pos_m0)); // R9
    AST_POS1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(step_out[1]) |-> $stable(pos_m1)); // R9

endmodule

bind step_sequencer step_sequencer_chk #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .POS_W     (POS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .step_out (step_out),
    .dir_out  (dir_out),
    .pos_m0   (pos_m0),
    .pos_m1   (pos_m1),
    .busy     (busy)
);

// File: tb/step_sequencer_tb.sv
module step_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_dir = 2'b00;
    logic [31:0] in_entry = '0;
    logic        in_last = 1'b0;
    logic [1:0]  step_out, dir_out;
    logic signed [31:0] pos_m0, pos_m1;
    logic        busy;

    int vec_cnt = 0;
    int bad_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    int r_cyc [0:99];
    int r_m   [0:99];
    int r_dir [0:99];
    int f_cyc [0:99];
    int nr = 0;
    int busy_fall = -1;
    logic [1:0] prev_step = 2'b00;
    logic prev_busy = 1'b0;
    logic [31:0] ent_buf [0:79];

    step_sequencer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dir(in_dir), .in_entry(in_entry), .in_last(in_last),
        .step_out(step_out), .dir_out(dir_out),
        .pos_m0(pos_m0), .pos_m1(pos_m1), .busy(busy)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log step and busy transitions on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            for (int m = 0; m < 2; m++) begin
                if (step_out[m] && !prev_step[m]) begin
                    if (nr < 100) begin
                        r_cyc[nr] = cyc;
                        r_m[nr]   = m;
                        r_dir[nr] = int'(dir_out);
                    end
                    nr++;
                end
                if (!step_out[m] && prev_step[m] && nr > 0 && nr <= 100)
                    f_cyc[nr-1] = cyc;
            end
            if (prev_busy && !busy) busy_fall = cyc;
        end
        prev_step = step_out;
        prev_busy = busy;
    end

    task automatic chk(input string req, input int act, input int exp);
        vec_cnt++;
        if (act != exp) begin
            bad_cnt++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ent(input int motor, input int d);
        return {motor[0], 31'(d)};
    endfunction

    task automatic send_cmd(input logic [1:0] dir_first, input logic [1:0] dir_last,
                            input int n, output int acc, output int waited);
        waited = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_entry = ent_buf[i];
            in_last  = (i == n - 1);
            in_dir   = (i == n - 1) ? dir_last : dir_first;
            while (!in_ready) begin
                waited++;
                @(negedge clk);
            end
            @(negedge clk);
        end
        acc = cyc;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 step_out", int'(step_out), 0);
        chk("R1 dir_out", int'(dir_out), 0);
        chk("R1 pos_m0", pos_m0, 0);
        chk("R1 pos_m1", pos_m1, 0);
    endtask

    task automatic test_single();
        int b, acc, w;
        b = nr;
        ent_buf[0] = ent(0, 10);
        ent_buf[1] = ent(0, 0);
        ent_buf[2] = ent(0, 5);
        send_cmd(2'b01, 2'b01, 3, acc, w);
        chk("R6 busy after accept", int'(busy), 1);
        wait_idle();
        chk("R2 step count", nr - b, 3);
        chk("R5 first rise", r_cyc[b], acc + 10 + 17);
        chk("R2 zero wait interval", r_cyc[b+1] - r_cyc[b], 216 + 1);
        chk("R5 in-command interval", r_cyc[b+2] - r_cyc[b+1], 216 + 5);
        for (int k = 0; k < 3; k++) begin
            chk("R2 motor select", r_m[b+k], 0);
            chk("R3 dir at rise", r_dir[b+k] & 1, 1);
            chk("R4 pulse width", f_cyc[b+k] - r_cyc[b+k], 200);
        end
        chk("R6 busy falls with last step", busy_fall, f_cyc[b+2]);
        chk("R9 pos_m0", pos_m0, 3);
        chk("R9 pos_m1", pos_m1, 0);
    endtask

    task automatic test_interleave();
        int b, acc, w;
        b = nr;
        ent_buf[0] = ent(1, 3);
        ent_buf[1] = ent(0, 7);
        ent_buf[2] = ent(1, 2);
        send_cmd(2'b01, 2'b01, 3, acc, w);
        wait_idle();
        chk("R2 interleave count", nr - b, 3);
        chk("R2 motor order 0", r_m[b], 1);
        chk("R2 motor order 1", r_m[b+1], 0);
        chk("R2 motor order 2", r_m[b+2], 1);
        chk("R3 dirs at motor1 rise", r_dir[b], 2'b01);
        chk("R3 dirs at motor0 rise", r_dir[b+1], 2'b01);
        chk("R5 first rise", r_cyc[b], acc + 3 + 17);
        chk("R5 interval a", r_cyc[b+1] - r_cyc[b], 216 + 7);
        chk("R5 interval b", r_cyc[b+2] - r_cyc[b+1], 216 + 2);
        chk("R9 pos_m0", pos_m0, 4);
        chk("R9 pos_m1", pos_m1, -2);
    endtask

    task automatic test_queue_full();
        int b, w, acc0, acc4;
        int mot [0:4];
        int dly [0:4];
        logic [1:0] dr [0:4];
        int exp_dir [0:4];
        mot = '{0, 1, 0, 1, 0};
        dly = '{4, 6, 1, 9, 2};
        dr  = '{2'b11, 2'b11, 2'b00, 2'b00, 2'b01};
        exp_dir = '{1, 1, 0, 0, 1};
        b = nr;
        for (int i = 0; i < 4; i++) begin
            int a;
            ent_buf[0] = ent(mot[i], dly[i]);
            send_cmd(dr[i], dr[i], 1, a, w);
            if (i == 0) acc0 = a;
        end
        chk("R7 ready low with four queued", int'(in_ready), 0);
        ent_buf[0] = ent(mot[4], dly[4]);
        send_cmd(dr[4], dr[4], 1, acc4, w);
        chk("R7 fifth command stalled", int'(w > 0), 1);
        chk("R7 fifth accepted after release", acc4, f_cyc[b] + 1);
        wait_idle();
        chk("R6 five steps", nr - b, 5);
        chk("R5 first rise", r_cyc[b], acc0 + dly[0] + 17);
        for (int k = 0; k < 5; k++) begin
            chk("R6 command order", r_m[b+k], mot[k]);
            chk("R3 direction bit", (r_dir[b+k] >> mot[k]) & 1, exp_dir[k]);
            if (k > 0)
                chk("R6 cross-command interval", r_cyc[b+k] - r_cyc[b+k-1], 217 + dly[k]);
        end
        chk("R9 pos_m0", pos_m0, 5);
        chk("R9 pos_m1", pos_m1, -2);
    endtask

    task automatic test_overflow();
        int b, acc, w;
        b = nr;
        for (int i = 0; i < 66; i++) ent_buf[i] = ent(1, 0);
        send_cmd(2'b00, 2'b10, 66, acc, w);
        wait_idle();
        chk("R8 steps capped at 64", nr - b, 64);
        chk("R7 dir from last beat", r_dir[b], 2'b11);
        chk("R8 last step width", f_cyc[b+63] - r_cyc[b+63], 200);
        chk("R9 pos_m1 after 64 up", pos_m1, 62);
        chk("R9 pos_m0 unchanged", pos_m0, 5);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_single();
        test_interleave();
        test_queue_full();
        test_overflow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vec_cnt++;
            bad_cnt++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

endmodule